// File: doc/BRIEF.md
# Vector element loop step sequencer

This block holds the loop position of one predicated vector instruction while it is replayed element by element. It keeps a source element step and a destination element step. Each has its own sub-element step, so packed sub-vectors can walk through their components on each side independently. Every cycle it reports the element each side should use next. A side whose sub-step is zero first jumps forward over elements that its predicate mask disables. A side in zeroing mode does not jump; it instead flags the disabled element as one to be written with zero.

The issue logic pulses `advance` each time the current element has been executed. On that pulse the sequencer either moves the counters forward and raises `holdPc`, so that the same instruction is fetched again, or it finishes the loop. When the loop finishes it raises `loopDone`, clears every counter and lets the program counter move on. A scalar instruction (vector mode off) finishes on its first advance. A vector length of zero in vector mode marks the instruction as skipped. `loopRst` clears the loop state at any time and takes priority over `advance`.

Top module: `vec_step_seq`

## Requirements
- R1: After the synchronous reset `rst`, or in the cycle after a `loopRst` pulse, both element steps and both sub-steps read 0. `loopRst` in the same cycle as `advance` wins: `loopDone` and `holdPc` stay low and the counters clear.
- R2: On an advance that does not end the loop, a side whose sub-step is below `subLen` increments its sub-step and keeps its element step. `subLen` is the last sub-step index, from 0 to 3.
- R3: On such an advance, a side whose sub-step equals `subLen` returns its sub-step to 0 and increments its element step by one.
- R4: In vector mode, with zeroing off and the side's sub-step at 0, the reported step is the lowest element index at or above the stored step whose mask bit is 1 and that is below `vecLen`. Mask bit i enables element i. If no such element exists, the reported step equals `vecLen`.
- R5: While a side's sub-step is nonzero, its reported step is the stored step, whatever the mask bit there.
- R6: A side in zeroing mode never skips. Its zeroed output is high when the mask bit at its reported step is 0 and that step is below `vecLen`.
- R7: In vector mode, an advance where either side reports step `vecLen`-1 with its sub-step equal to `subLen` ends the loop. At that advance `loopDone` is high and `holdPc` is low, and afterwards all four counters read 0.
- R8: An advance that does not end the loop drives `holdPc` high and `loopDone` low in that cycle. With `advance` low, both are low.
- R9: With vector mode off, every advance ends the loop and no skipping is applied.
- R10: In vector mode with `vecLen` equal to 0, `insnSkip` is high and an advance ends the loop.
- R11: An advance while either side reports step equal to `vecLen` (no enabled element is left) ends the loop.
- R12: While the vector length, sub-vector length and mode are unchanged since the last clear, no reported step exceeds `vecLen`. `vecLen` must not exceed the mask width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vecMode | input | 1 | Instruction runs as a vector loop |
| vecLen | input | 7 | Number of elements |
| subLen | input | 2 | Last sub-element index (components minus one) |
| srcMask | input | 64 | Source predicate, all ones when unpredicated |
| dstMask | input | 64 | Destination predicate, all ones when unpredicated |
| srcZeroMode | input | 1 | Source side zeroes instead of skipping |
| dstZeroMode | input | 1 | Destination side zeroes instead of skipping |
| advance | input | 1 | Current element executed, step the loop |
| loopRst | input | 1 | Clear loop state |
| srcStep | output | 7 | Source element to use now |
| srcSub | output | 2 | Source sub-element step |
| dstStep | output | 7 | Destination element to use now |
| dstSub | output | 2 | Destination sub-element step |
| srcZeroed | output | 1 | Source element is masked and must read as zero |
| dstZeroed | output | 1 | Destination element is masked and must be written as zero |
| loopDone | output | 1 | This advance finishes the loop |
| holdPc | output | 1 | This advance repeats the same instruction |
| insnSkip | output | 1 | Vector instruction with zero length, to be skipped |

## Verification
The bench walks sub-vectors through wrap-around. A sequencer that shared one sub-counter, or that wrapped one index early or late, would report the wrong element. It uses sparse masks to catch a scan that picks the highest set bit, scans past `vecLen`, or fails to settle on `vecLen` when the mask runs out. It changes a mask while a sub-step is nonzero, which exposes skipping done at the wrong moment. It also ends loops from the destination side alone, from an exhausted mask, from zero length and from scalar mode, so a design that waits for both sides, or repeats the instruction one time too many, shows a wrong `loopDone`/`holdPc` pair.

// File: rtl/vls_pkg.sv
package vls_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero all counters
    logic commit;  // take one loop step
  } ctlStrobe_t;

  localparam int LANES = 2;  // lane 0 = source, lane 1 = destination
endpackage

// File: rtl/vls_scan.sv
// Priority scan: lowest enabled element at or above fromStep, below lenLimit.
module vls_scan #(
  parameter int STEP_W = 7,
  parameter int MASK_W = 64
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [STEP_W-1:0] fromStep,
  input  logic [STEP_W-1:0] lenLimit,
  output logic [STEP_W-1:0] hitStep
);
  always_comb begin
    hitStep = lenLimit;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (mask[i] && (STEP_W'(i) >= fromStep) && (STEP_W'(i) < lenLimit))
        hitStep = STEP_W'(i);
    end
  end
endmodule

// File: rtl/vls_lane.sv
// One side (source or destination) of the loop: element step and sub-step.
module vls_lane
  import vls_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vecMode,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subLen,
  input  logic [MASK_W-1:0] mask,
  input  logic              zeroMode,
  input  ctlStrobe_t        ctl,
  output logic [STEP_W-1:0] effStep,
  output logic [SUB_W-1:0]  curSub,
  output logic              zeroed,
  output logic              atFinal,
  output logic              exhausted
);
  localparam int IDX_W = $clog2(MASK_W);
  localparam logic [STEP_W:0] MASK_LIM = (STEP_W + 1)'(MASK_W);

  logic [STEP_W-1:0] rawStep;
  logic [SUB_W-1:0]  rawSub;
  logic [STEP_W-1:0] scanStep;
  logic              scanOn;
  logic              maskHit;
  logic [IDX_W-1:0]  bitIdx;

  vls_scan #(.STEP_W(STEP_W), .MASK_W(MASK_W)) scan_i (
    .mask    (mask),
    .fromStep(rawStep),
    .lenLimit(vecLen),
    .hitStep (scanStep)
  );

  // skipping only at the start of an element, never in zeroing mode
  assign scanOn  = vecMode && (rawSub == '0) && !zeroMode;
  assign effStep = scanOn ? scanStep : rawStep;
  assign curSub  = rawSub;
  assign bitIdx  = IDX_W'(effStep);
  assign maskHit = ({1'b0, effStep} < MASK_LIM) && mask[bitIdx];

  assign zeroed    = vecMode && zeroMode && (effStep < vecLen) && !maskHit;
  assign atFinal   = (vecLen != '0) && (effStep == vecLen - STEP_W'(1)) &&
                     (rawSub == subLen);
  assign exhausted = vecMode && (effStep == vecLen);

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      rawStep <= '0;
      rawSub  <= '0;
    end else if (ctl.commit) begin
      if (rawSub == subLen) begin
        rawSub  <= '0;
        rawStep <= (effStep == vecLen) ? effStep : effStep + STEP_W'(1);
      end else begin
        rawSub  <= rawSub + SUB_W'(1);
        rawStep <= effStep;
      end
    end
  end

  // configuration-steady tracker, used only to qualify the bound checks
  logic [STEP_W-1:0] lastLen;
  logic [SUB_W-1:0]  lastSubLen;
  logic              lastMode;
  logic              steadyReg;
  logic              steadyNow;

  assign steadyNow = steadyReg && (lastLen == vecLen) &&
                     (lastSubLen == subLen) && (lastMode == vecMode);

  always_ff @(posedge clk) begin
    lastLen    <= vecLen;
    lastSubLen <= subLen;
    lastMode   <= vecMode;
    if (rst || ctl.clear) steadyReg <= 1'b1;
    else                  steadyReg <= steadyNow;
  end

  assert_step_within_len_R12: assert property (@(posedge clk) disable iff (rst)
    steadyNow |-> (effStep <= vecLen));

  assert_sub_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    steadyNow |-> (rawSub <= subLen));

  assert_sub_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl.commit && !ctl.clear && rawSub != subLen) |=>
      (rawSub == $past(rawSub) + SUB_W'(1)) && (rawStep == $past(effStep)));

  assert_sub_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.commit && !ctl.clear && rawSub == subLen && effStep != vecLen) |=>
      (rawSub == '0) && (rawStep == $past(effStep) + STEP_W'(1)));

  assert_clear_zeroes_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> (rawStep == '0) && (rawSub == '0));

  assert_skip_lands_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    (scanOn && effStep < vecLen) |-> maskHit);

  assert_no_skip_nonzero_sub_R5: assert property (@(posedge clk) disable iff (rst)
    (rawSub != '0) |-> (effStep == rawStep));

  assert_zeroed_needs_mode_R6: assert property (@(posedge clk) disable iff (rst)
    zeroed |-> zeroMode);
endmodule

// File: rtl/vls_datapath.sv
// Source and destination lanes side by side.
module vls_datapath
  import vls_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         vecMode,
  input  logic [STEP_W-1:0]            vecLen,
  input  logic [SUB_W-1:0]             subLen,
  input  logic [LANES-1:0][MASK_W-1:0] laneMask,
  input  logic [LANES-1:0]             laneZeroMode,
  input  ctlStrobe_t                   ctl,
  output logic [LANES-1:0][STEP_W-1:0] laneStep,
  output logic [LANES-1:0][SUB_W-1:0]  laneSub,
  output logic [LANES-1:0]             laneZeroed,
  output logic [LANES-1:0]             laneFinal,
  output logic [LANES-1:0]             laneExhausted
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vls_lane #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) lane_i (
      .clk      (clk),
      .rst      (rst),
      .vecMode  (vecMode),
      .vecLen   (vecLen),
      .subLen   (subLen),
      .mask     (laneMask[g]),
      .zeroMode (laneZeroMode[g]),
      .ctl      (ctl),
      .effStep  (laneStep[g]),
      .curSub   (laneSub[g]),
      .zeroed   (laneZeroed[g]),
      .atFinal  (laneFinal[g]),
      .exhausted(laneExhausted[g])
    );
  end
endmodule

// File: rtl/vls_control.sv
// Loop end decision and strobe generation.
module vls_control
  import vls_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vecMode,
  input  logic [STEP_W-1:0] vecLen,
  input  logic              advance,
  input  logic              loopRst,
  input  logic [LANES-1:0]  laneFinal,
  input  logic [LANES-1:0]  laneExhausted,
  output ctlStrobe_t        ctl,
  output logic              loopDone,
  output logic              holdPc,
  output logic              insnSkip
);
  logic loopEnd;
  logic stepNow;

  assign insnSkip = vecMode && (vecLen == '0);
  // first side to reach its end finishes the loop
  assign loopEnd  = !vecMode || insnSkip || (|laneFinal) || (|laneExhausted);
  assign stepNow  = advance && !loopRst;

  assign loopDone   = stepNow && loopEnd;
  assign holdPc     = stepNow && !loopEnd;
  assign ctl.clear  = loopRst || loopDone;
  assign ctl.commit = holdPc;

  assert_done_hold_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loopDone, holdPc}));

  assert_scalar_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (advance && !loopRst && !vecMode) |-> loopDone);

  assert_reset_priority_R1: assert property (@(posedge clk) disable iff (rst)
    loopRst |-> (!loopDone && !holdPc));

  assert_zero_len_ends_R10: assert property (@(posedge clk) disable iff (rst)
    (advance && !loopRst && insnSkip) |-> loopDone);
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vls_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vecMode,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subLen,
  input  logic [MASK_W-1:0] srcMask,
  input  logic [MASK_W-1:0] dstMask,
  input  logic              srcZeroMode,
  input  logic              dstZeroMode,
  input  logic              advance,
  input  logic              loopRst,
  output logic [STEP_W-1:0] srcStep,
  output logic [SUB_W-1:0]  srcSub,
  output logic [STEP_W-1:0] dstStep,
  output logic [SUB_W-1:0]  dstSub,
  output logic              srcZeroed,
  output logic              dstZeroed,
  output logic              loopDone,
  output logic              holdPc,
  output logic              insnSkip
);
  ctlStrobe_t                   ctl;
  logic [LANES-1:0][MASK_W-1:0] laneMask;
  logic [LANES-1:0]             laneZeroMode;
  logic [LANES-1:0][STEP_W-1:0] laneStep;
  logic [LANES-1:0][SUB_W-1:0]  laneSub;
  logic [LANES-1:0]             laneZeroed;
  logic [LANES-1:0]             laneFinal;
  logic [LANES-1:0]             laneExhausted;

  assign laneMask     = {dstMask, srcMask};
  assign laneZeroMode = {dstZeroMode, srcZeroMode};

  vls_datapath #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) dp_i (
    .clk          (clk),
    .rst          (rst),
    .vecMode      (vecMode),
    .vecLen       (vecLen),
    .subLen       (subLen),
    .laneMask     (laneMask),
    .laneZeroMode (laneZeroMode),
    .ctl          (ctl),
    .laneStep     (laneStep),
    .laneSub      (laneSub),
    .laneZeroed   (laneZeroed),
    .laneFinal    (laneFinal),
    .laneExhausted(laneExhausted)
  );

  vls_control #(.STEP_W(STEP_W)) ctl_i (
    .clk          (clk),
    .rst          (rst),
    .vecMode      (vecMode),
    .vecLen       (vecLen),
    .advance      (advance),
    .loopRst      (loopRst),
    .laneFinal    (laneFinal),
    .laneExhausted(laneExhausted),
    .ctl          (ctl),
    .loopDone     (loopDone),
    .holdPc       (holdPc),
    .insnSkip     (insnSkip)
  );

  assign srcStep   = laneStep[0];
  assign dstStep   = laneStep[1];
  assign srcSub    = laneSub[0];
  assign dstSub    = laneSub[1];
  assign srcZeroed = laneZeroed[0];
  assign dstZeroed = laneZeroed[1];
endmodule

// File: tb/vec_step_seq_tb_top.sv
module vec_step_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vecMode = 1'b0;
  logic [6:0]  vecLen = '0;
  logic [1:0]  subLen = '0;
  logic [63:0] srcMask = ONES;
  logic [63:0] dstMask = ONES;
  logic        srcZeroMode = 1'b0;
  logic        dstZeroMode = 1'b0;
  logic        advance = 1'b0;
  logic        loopRst = 1'b0;
  logic [6:0]  srcStep, dstStep;
  logic [1:0]  srcSub, dstSub;
  logic        srcZeroed, dstZeroed, loopDone, holdPc, insnSkip;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_step_seq dut_i (
    .clk(clk), .rst(rst), .vecMode(vecMode), .vecLen(vecLen), .subLen(subLen),
    .srcMask(srcMask), .dstMask(dstMask), .srcZeroMode(srcZeroMode),
    .dstZeroMode(dstZeroMode), .advance(advance), .loopRst(loopRst),
    .srcStep(srcStep), .srcSub(srcSub), .dstStep(dstStep), .dstSub(dstSub),
    .srcZeroed(srcZeroed), .dstZeroed(dstZeroed), .loopDone(loopDone),
    .holdPc(holdPc), .insnSkip(insnSkip)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  // configure a loop and clear it with loopRst; returns just after the edge
  task automatic setup(input logic vm, input int vl, input int sl,
                       input logic [63:0] sm, input logic [63:0] dm,
                       input logic sz, input logic dz);
    vecMode = vm; vecLen = 7'(vl); subLen = 2'(sl);
    srcMask = sm; dstMask = dm; srcZeroMode = sz; dstZeroMode = dz;
    loopRst = 1'b1;
    @(posedge clk); #1;
    loopRst = 1'b0;
    #1;
  endtask

  // one advance; samples the loop outcome before the edge
  task automatic adv(output logic d, output logic h);
    advance = 1'b1;
    #1;
    d = loopDone; h = holdPc;
    @(posedge clk); #1;
    advance = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1", "srcStep after reset", srcStep, 0);
    chk("R1", "dstStep after reset", dstStep, 0);
    chk("R1", "srcSub after reset", srcSub, 0);
    chk("R1", "dstSub after reset", dstSub, 0);
    chk("R8", "holdPc idle", holdPc, 0);
    chk("R8", "loopDone idle", loopDone, 0);
  endtask

  task automatic t_subvec();
    logic d, h;
    setup(1, 3, 1, ONES, ONES, 0, 0);
    adv(d, h);
    chk("R8", "holdPc running", h, 1);
    chk("R8", "loopDone running", d, 0);
    chk("R2", "srcSub step", srcSub, 1);
    chk("R2", "srcStep held", srcStep, 0);
    chk("R2", "dstSub step", dstSub, 1);
    adv(d, h);
    chk("R3", "srcSub wrap", srcSub, 0);
    chk("R3", "srcStep inc", srcStep, 1);
    chk("R3", "dstStep inc", dstStep, 1);
    adv(d, h); adv(d, h); adv(d, h);
    chk("R3", "srcStep at last", srcStep, 2);
    chk("R3", "srcSub at last", srcSub, 1);
    adv(d, h);
    chk("R7", "loopDone at final", d, 1);
    chk("R7", "holdPc at final", h, 0);
    chk("R7", "srcStep cleared", srcStep, 0);
    chk("R7", "dstSub cleared", dstSub, 0);
  endtask

  task automatic t_skip();
    logic d, h;
    setup(1, 8, 0, 64'hA4, ONES, 0, 0);
    chk("R4", "first enabled src", srcStep, 2);
    chk("R4", "dst all enabled", dstStep, 0);
    adv(d, h);
    chk("R4", "skip to 5", srcStep, 5);
    chk("R4", "dst next", dstStep, 1);
    adv(d, h);
    chk("R4", "skip to 7", srcStep, 7);
    adv(d, h);
    chk("R7", "source side ends loop", d, 1);
    chk("R7", "dst cleared", dstStep, 0);
  endtask

  task automatic t_exhaust();
    logic d, h;
    setup(1, 6, 0, 64'h2, ONES, 0, 0);
    chk("R4", "only enabled src", srcStep, 1);
    adv(d, h);
    chk("R11", "no enabled left reads VL", srcStep, 6);
    chk("R12", "step within VL", int'(srcStep <= 7'd6), 1);
    adv(d, h);
    chk("R11", "exhausted ends loop", d, 1);
    chk("R11", "no hold after exhaust", h, 0);
  endtask

  task automatic t_subhold();
    logic d, h;
    setup(1, 4, 1, 64'h5, ONES, 0, 0);
    chk("R4", "src starts 0", srcStep, 0);
    adv(d, h);
    srcMask = 64'h4;
    #1;
    chk("R5", "no skip mid sub-vector", srcStep, 0);
    chk("R5", "sub still 1", srcSub, 1);
    adv(d, h);
    chk("R4", "skip after wrap", srcStep, 2);
  endtask

  task automatic t_zeroing();
    logic d, h;
    setup(1, 4, 0, ONES, 64'h5, 0, 1);
    chk("R6", "dst enabled not zeroed", dstZeroed, 0);
    adv(d, h);
    chk("R6", "dst not skipped", dstStep, 1);
    chk("R6", "dst zeroed", dstZeroed, 1);
    chk("R6", "src not zeroed", srcZeroed, 0);
  endtask

  task automatic t_scalar();
    logic d, h;
    setup(0, 4, 0, 64'h8, ONES, 0, 0);
    chk("R9", "no scan in scalar", srcStep, 0);
    adv(d, h);
    chk("R9", "scalar ends at once", d, 1);
    chk("R9", "scalar no hold", h, 0);
  endtask

  task automatic t_zero_len();
    logic d, h;
    setup(1, 0, 0, ONES, ONES, 0, 0);
    chk("R10", "insnSkip high", insnSkip, 1);
    adv(d, h);
    chk("R10", "zero length ends", d, 1);
    setup(1, 3, 0, ONES, ONES, 0, 0);
    chk("R10", "insnSkip low with length", insnSkip, 0);
  endtask

  task automatic t_dst_end();
    logic d, h;
    setup(1, 4, 0, ONES, 64'h8, 0, 0);
    chk("R4", "dst jumps to 3", dstStep, 3);
    adv(d, h);
    chk("R7", "destination side ends loop", d, 1);
    chk("R7", "src cleared", srcStep, 0);
  endtask

  task automatic t_rst_prio();
    logic d, h;
    setup(1, 4, 0, ONES, ONES, 0, 0);
    adv(d, h);
    chk("R3", "src at 1", srcStep, 1);
    loopRst = 1'b1; advance = 1'b1;
    #1;
    chk("R1", "no done under loopRst", loopDone, 0);
    chk("R1", "no hold under loopRst", holdPc, 0);
    @(posedge clk); #1;
    loopRst = 1'b0; advance = 1'b0;
    #1;
    chk("R1", "loopRst clears src", srcStep, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    t_reset();
    t_subvec();
    t_skip();
    t_exhaust();
    t_subhold();
    t_zeroing();
    t_scalar();
    t_zero_len();
    t_dst_end();
    t_rst_prio();
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule